// File: doc/BRIEF.md
# System Call Trap Dispatch Unit

This unit sits beside the execute stage of a small in-order core and handles entry into, and return from, system call traps. Each cycle the upstream decoder may offer a system call (`sc_valid`), a trap return (`ret_valid`) or an asynchronous trap from another source (`ext_valid`). The instruction word tells the unit which variant it has. For an entry, the unit computes the 17-bit trap vector and applies the facility check for the vectored call. It picks the register pair that receives the return address and the old machine state, and it derives the new machine state. For a return, it picks the pair to read back. It then redirects fetch and reports the new translation, privilege, endianness and width mode.

The save registers live in a small model of a paired special-register RAM. The even half of each row holds an address and the odd half holds a machine-state word. The three pairs are the ordinary save pair, the hypervisor save pair and the link/count pair. Every result is registered and appears one clock after the request is sampled. The unit also holds the machine state register and the two facility-control fields that it uses.

Top module: `syscall_dispatch`

## Requirements
- R1: After reset `msr_out` has only bit 63 (64-bit mode) and bit 0 (little-endian) set. `fscr_out` has bit 12 (vectored-call enable) set and bits 59:56 (cause code) zero. `redir_valid`, `redir_trap` and `save_en` are low.
- R2: A system call with instruction bit 1 set redirects to 0xC00. It writes the current address plus 4 and the old MSR into the ordinary save pair (row 0).
- R3: A system call with instruction bit 1 clear is a vectored call. It redirects to 0x17000 plus 32 times instruction bits 11:5, and it saves the current address plus 4 and the old MSR into the link/count pair (row 2).
- R4: A vectored call taken with MSR bit 14 (problem state) set and FSCR bit 12 clear instead redirects to 0xF60. It saves into row 0 and writes 0xC into FSCR bits 59:56. If either condition is absent, the call proceeds as in R3 and the cause code is left unchanged.
- R5: A write on the FSCR port loads bit 12 and bits 59:56 from the write data. All other FSCR bits read as zero.
- R6: On any entry the new MSR sets bits 63 and 0. It clears bits 14, 10, 9, 11, 8, 5 and 4. It clears bits 15 and 1 only when the entry is not a vectored call. All other bits are kept.
- R7: An external trap takes priority over an instruction offered in the same cycle. It redirects to its vector with the two low bits cleared and saves `cur_pc` and the old MSR. The pair is row 1 when `ext_hv` is set and row 0 otherwise.
- R8: A return with instruction bit 7 set reads row 2. Otherwise bit 9 clear selects row 0 and bit 9 set selects row 1. The return redirects to the saved address with its two low bits cleared, loads the MSR from the saved word and writes no pair.
- R9: On a return, `mode_xlate` equals saved bit 5 OR saved bit 14. `mode_priv` is the inverse of saved bit 14. `mode_le` is saved bit 0 and `mode_64` is saved bit 63.
- R10: A redirect appears for exactly the cycle after an accepted request. Cycles with no request give no redirect and no save.
- R11: A write on the MSR port loads the MSR when no entry or return occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sc_valid | input | 1 | System call offered |
| ret_valid | input | 1 | Trap return offered |
| insn | input | 32 | Instruction word of the offered operation |
| cur_pc | input | XLEN | Address of the offered instruction or trapped point |
| ext_valid | input | 1 | Trap from another source |
| ext_hv | input | 1 | External trap is a hypervisor trap |
| ext_vec | input | 12 | External trap vector |
| msr_wr_en | input | 1 | MSR write strobe |
| msr_wr_data | input | XLEN | MSR write value |
| fscr_wr_en | input | 1 | Facility control write strobe |
| fscr_wr_data | input | XLEN | Facility control write value |
| redir_valid | output | 1 | Fetch redirect this cycle |
| redir_trap | output | 1 | Redirect is a trap entry |
| redir_addr | output | XLEN | Redirect fetch address |
| mode_xlate | output | 1 | Translation on after return |
| mode_priv | output | 1 | Privileged after return |
| mode_le | output | 1 | Little-endian after return |
| mode_64 | output | 1 | 64-bit mode after return |
| save_en | output | 1 | A save pair was written |
| save_idx | output | 2 | Row of the written save pair |
| msr_out | output | XLEN | Current machine state |
| fscr_out | output | XLEN | Current facility control value |

## Verification
A wrong pair selection cannot be seen at entry. It shows up at the later return, as a wrong redirect address or a restored MSR that differs from the one saved. The sweeps therefore always pair each entry with a return. A wrong vector, facility decision or entry MSR is visible on the outputs one clock after the request. A wrong cause code stays in `fscr_out` until software rewrites it.

// File: rtl/sdu_pkg.sv
// Package: shared constants and types for the system call dispatch unit.
// Assumes a 64-bit machine state word with bit 0 as the least significant bit.
package sdu_pkg;
    localparam int MSR_SF  = 63;
    localparam int MSR_EE  = 15;
    localparam int MSR_PR  = 14;
    localparam int MSR_FE0 = 11;
    localparam int MSR_SE  = 10;
    localparam int MSR_BE  = 9;
    localparam int MSR_FE1 = 8;
    localparam int MSR_IR  = 5;
    localparam int MSR_DR  = 4;
    localparam int MSR_RI  = 1;
    localparam int MSR_LE  = 0;

    localparam int FSCR_VCALL = 12;
    localparam int FSCR_CAUSE_LO = 56;
    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_VCALL = 4'hC;

    localparam int VEC_W = 17;
    localparam int OFS_W = 12;
    localparam int PAGE_W = VEC_W - OFS_W;
    localparam logic [VEC_W-1:0]  VEC_LEGACY = 17'h00C00;
    localparam logic [VEC_W-1:0]  VEC_FACIL  = 17'h00F60;
    localparam logic [PAGE_W-1:0] VCALL_PAGE = 5'h17;
    localparam int LEVEL_W = 7;
    localparam int SLOT_SH = 5;

    localparam int PAIR_W = 2;
    typedef enum logic [PAIR_W-1:0] {
        PAIR_SAVE  = 2'd0,
        PAIR_HSAVE = 2'd1,
        PAIR_LINK  = 2'd2
    } pair_e;
endpackage

// File: rtl/sdu_decode.sv
// Module: combinational request decode. Picks entry or return, computes the
// trap vector, the facility check and the register pair. Assumes sc_valid and
// ret_valid are not both set; if they are, the system call wins.
module sdu_decode
    import sdu_pkg::*;
(
    input  logic                 sc_valid,
    input  logic                 ret_valid,
    input  logic [31:0]          insn,
    input  logic                 ext_valid,
    input  logic                 ext_hv,
    input  logic [OFS_W-1:0]     ext_vec,
    input  logic                 in_problem,
    input  logic                 vcall_en,
    output logic                 take_entry,
    output logic                 take_ret,
    output logic                 entry_vcall,
    output logic                 facil_trap,
    output logic                 from_ext,
    output logic [VEC_W-1:0]     vec,
    output pair_e                save_pair,
    output pair_e                load_pair
);
    // Priority of save pairs: hypervisor first, then vectored call, then ordinary.
    function automatic pair_e pick_save(input logic hv, input logic vc);
        if (hv)      return PAIR_HSAVE;
        else if (vc) return PAIR_LINK;
        else         return PAIR_SAVE;
    endfunction

    // Decode the request class and derive vector and pairs.
    always_comb begin
        take_entry  = 1'b0;
        take_ret    = 1'b0;
        entry_vcall = 1'b0;
        facil_trap  = 1'b0;
        from_ext    = 1'b0;
        vec         = '0;
        load_pair   = PAIR_SAVE;
        if (ext_valid) begin
            take_entry = 1'b1;
            from_ext   = 1'b1;
            vec        = {{PAGE_W{1'b0}}, ext_vec};
        end else if (sc_valid) begin
            take_entry = 1'b1;
            if (insn[1]) begin
                vec = VEC_LEGACY;
            end else if (in_problem && !vcall_en) begin
                facil_trap = 1'b1;
                vec        = VEC_FACIL;
            end else begin
                entry_vcall = 1'b1;
                vec = {VCALL_PAGE, insn[SLOT_SH +: LEVEL_W], {SLOT_SH{1'b0}}};
            end
        end else if (ret_valid) begin
            take_ret = 1'b1;
            if (insn[7])      load_pair = PAIR_LINK;
            else if (!insn[9]) load_pair = PAIR_SAVE;
            else              load_pair = PAIR_HSAVE;
        end
        save_pair = pick_save(ext_valid && ext_hv, entry_vcall);
    end
endmodule

// File: rtl/sdu_msr_logic.sv
// Module: combinational machine-state logic. Builds the MSR written on trap
// entry and the mode bits taken from a saved MSR on return.
module sdu_msr_logic
    import sdu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] cur_msr,
    input  logic            vcall,
    input  logic [XLEN-1:0] saved_msr,
    output logic [XLEN-1:0] entry_msr,
    output logic            ret_xlate,
    output logic            ret_priv,
    output logic            ret_le,
    output logic            ret_64
);
    // Entry MSR: force width and endianness, drop privilege and debug state.
    always_comb begin
        entry_msr = cur_msr;
        entry_msr[MSR_SF]  = 1'b1;
        entry_msr[MSR_LE]  = 1'b1;
        entry_msr[MSR_PR]  = 1'b0;
        entry_msr[MSR_SE]  = 1'b0;
        entry_msr[MSR_BE]  = 1'b0;
        entry_msr[MSR_FE0] = 1'b0;
        entry_msr[MSR_FE1] = 1'b0;
        entry_msr[MSR_IR]  = 1'b0;
        entry_msr[MSR_DR]  = 1'b0;
        if (!vcall) begin
            entry_msr[MSR_EE] = 1'b0;
            entry_msr[MSR_RI] = 1'b0;
        end
    end

    // Return mode: translation follows IR or problem state.
    always_comb begin
        ret_xlate = saved_msr[MSR_IR] | saved_msr[MSR_PR];
        ret_priv  = ~saved_msr[MSR_PR];
        ret_le    = saved_msr[MSR_LE];
        ret_64    = saved_msr[MSR_SF];
    end
endmodule

// File: rtl/sdu_pair_ram.sv
// Module: paired special-register storage. Each row has an even (address) and
// an odd (state) word that are written together. Reads are asynchronous.
// Rows carry no reset; callers read only rows written earlier.
module sdu_pair_ram #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_even,
    input  logic [XLEN-1:0]  wr_odd,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_even,
    output logic [XLEN-1:0]  rd_odd
);
    localparam int ROWS = 2 ** IDX_W;

    logic [XLEN-1:0] even_q [ROWS];
    logic [XLEN-1:0] odd_q  [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // Row storage: load both halves when this row is addressed.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(r)) begin
                even_q[r] <= wr_even;
                odd_q[r]  <= wr_odd;
            end
        end
    end

    // Read port.
    always_comb begin
        rd_even = even_q[rd_idx];
        rd_odd  = odd_q[rd_idx];
    end
endmodule

// File: rtl/syscall_dispatch.sv
// Module: system call trap dispatch top. Registers every result one clock
// after the request. Holds the MSR, the vectored-call enable and the cause
// field. Assumes XLEN is at least 64.
module syscall_dispatch
    import sdu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_valid,
    input  logic              ret_valid,
    input  logic [31:0]       insn,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              ext_valid,
    input  logic              ext_hv,
    input  logic [11:0]       ext_vec,
    input  logic              msr_wr_en,
    input  logic [XLEN-1:0]   msr_wr_data,
    input  logic              fscr_wr_en,
    input  logic [XLEN-1:0]   fscr_wr_data,
    output logic              redir_valid,
    output logic              redir_trap,
    output logic [XLEN-1:0]   redir_addr,
    output logic              mode_xlate,
    output logic              mode_priv,
    output logic              mode_le,
    output logic              mode_64,
    output logic              save_en,
    output logic [1:0]        save_idx,
    output logic [XLEN-1:0]   msr_out,
    output logic [XLEN-1:0]   fscr_out
);
    localparam logic [XLEN-1:0] MSR_RESET = (XLEN'(1) << MSR_SF) | (XLEN'(1) << MSR_LE);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    logic               msr_q_pr;
    logic [XLEN-1:0]    msr_q;
    logic               vcall_en_q;
    logic [CAUSE_W-1:0] cause_q;

    logic               take_entry, take_ret, entry_vcall, facil_trap, from_ext;
    logic [VEC_W-1:0]   vec;
    pair_e              save_pair, load_pair;
    logic [XLEN-1:0]    entry_msr, rd_even, rd_odd, save_addr;
    logic               r_xlate, r_priv, r_le, r_64;

    assign msr_q_pr = msr_q[MSR_PR];

    sdu_decode u_dec (
        .sc_valid    (sc_valid),
        .ret_valid   (ret_valid),
        .insn        (insn),
        .ext_valid   (ext_valid),
        .ext_hv      (ext_hv),
        .ext_vec     (ext_vec),
        .in_problem  (msr_q_pr),
        .vcall_en    (vcall_en_q),
        .take_entry  (take_entry),
        .take_ret    (take_ret),
        .entry_vcall (entry_vcall),
        .facil_trap  (facil_trap),
        .from_ext    (from_ext),
        .vec         (vec),
        .save_pair   (save_pair),
        .load_pair   (load_pair)
    );

    sdu_msr_logic #(.XLEN(XLEN)) u_msr (
        .cur_msr   (msr_q),
        .vcall     (entry_vcall),
        .saved_msr (rd_odd),
        .entry_msr (entry_msr),
        .ret_xlate (r_xlate),
        .ret_priv  (r_priv),
        .ret_le    (r_le),
        .ret_64    (r_64)
    );

    // Saved return point: next instruction for calls, trapped point otherwise.
    assign save_addr = from_ext ? cur_pc : cur_pc + XLEN'(4);

    sdu_pair_ram #(.XLEN(XLEN), .IDX_W(PAIR_W)) u_ram (
        .clk     (clk),
        .wr_en   (take_entry),
        .wr_idx  (save_pair),
        .wr_even (save_addr),
        .wr_odd  (msr_q),
        .rd_idx  (load_pair),
        .rd_even (rd_even),
        .rd_odd  (rd_odd)
    );

    // Machine state register update: entry, then return, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)          msr_q <= MSR_RESET;
        else if (take_entry) msr_q <= entry_msr;
        else if (take_ret)   msr_q <= rd_odd;
        else if (msr_wr_en)  msr_q <= msr_wr_data;
    end

    // Facility control fields: software write, or cause code on facility trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcall_en_q <= 1'b1;
            cause_q    <= '0;
        end else if (fscr_wr_en) begin
            vcall_en_q <= fscr_wr_data[FSCR_VCALL];
            cause_q    <= fscr_wr_data[FSCR_CAUSE_LO +: CAUSE_W];
        end else if (facil_trap) begin
            cause_q <= CAUSE_VCALL;
        end
    end

    // Registered redirect, mode and save report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_trap  <= 1'b0;
            redir_addr  <= '0;
            mode_xlate  <= 1'b0;
            mode_priv   <= 1'b0;
            mode_le     <= 1'b0;
            mode_64     <= 1'b0;
            save_en     <= 1'b0;
            save_idx    <= '0;
        end else begin
            redir_valid <= take_entry | take_ret;
            redir_trap  <= take_entry;
            save_en     <= take_entry;
            mode_xlate  <= take_ret & r_xlate;
            mode_priv   <= take_ret & r_priv;
            mode_le     <= take_ret & r_le;
            mode_64     <= take_ret & r_64;
            if (take_entry) begin
                redir_addr <= {{(XLEN-VEC_W){1'b0}}, vec[VEC_W-1:2], 2'b00};
                save_idx   <= save_pair;
            end else if (take_ret) begin
                redir_addr <= rd_even & ALIGN_MASK;
            end
        end
    end

    // Port views of internal state.
    always_comb begin
        msr_out = msr_q;
        fscr_out = '0;
        fscr_out[FSCR_VCALL] = vcall_en_q;
        fscr_out[FSCR_CAUSE_LO +: CAUSE_W] = cause_q;
    end
endmodule

// File: rtl/sdu_checker.sv
// Module: temporal checks on the dispatch unit ports, bound to every instance.
module sdu_checker
    import sdu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sc_valid,
    input logic            ret_valid,
    input logic            ext_valid,
    input logic [31:0]     insn,
    input logic            fscr_wr_en,
    input logic [XLEN-1:0] msr_out,
    input logic [XLEN-1:0] fscr_out,
    input logic            redir_valid,
    input logic            redir_trap,
    input logic [XLEN-1:0] redir_addr,
    input logic            save_en,
    input logic [1:0]      save_idx
);
    a_r10_redirect_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid || ret_valid || ext_valid) |=> redir_valid);

    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_valid || ret_valid || ext_valid) |=> (!redir_valid && !save_en));

    a_r3_vcall_page: assert property (@(posedge clk) disable iff (!rst_n)
        (save_en && save_idx == 2'd2) |-> (redir_addr[16:12] == 5'h17 && redir_addr[4:0] == 5'd0));

    a_r6_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
        redir_trap |-> (msr_out[MSR_SF] && msr_out[MSR_LE] && !msr_out[MSR_PR]
                        && !msr_out[MSR_IR] && !msr_out[MSR_DR]));

    a_r4_facility_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !ext_valid && !insn[1] && msr_out[MSR_PR] && !fscr_out[FSCR_VCALL] && !fscr_wr_en)
        |=> (redir_addr == XLEN'(17'hF60) && fscr_out[59:56] == 4'hC && save_idx == 2'd0));

    a_r8_return_no_save: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !sc_valid && !ext_valid) |=> (!save_en && !redir_trap));
endmodule

bind syscall_dispatch sdu_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sc_valid    (sc_valid),
    .ret_valid   (ret_valid),
    .ext_valid   (ext_valid),
    .insn        (insn),
    .fscr_wr_en  (fscr_wr_en),
    .msr_out     (msr_out),
    .fscr_out    (fscr_out),
    .redir_valid (redir_valid),
    .redir_trap  (redir_trap),
    .redir_addr  (redir_addr),
    .save_en     (save_en),
    .save_idx    (save_idx)
);

// File: tb/syscall_dispatch_test.sv
// Bench: sweeps call levels, facility settings, return variants and modes.
module syscall_dispatch_test;
    localparam int XLEN = 64;
    localparam logic [63:0] B_SF = 64'h1 << 63, B_EE = 64'h1 << 15, B_PR = 64'h1 << 14,
        B_FE0 = 64'h1 << 11, B_SE = 64'h1 << 10, B_BE = 64'h1 << 9, B_FE1 = 64'h1 << 8,
        B_IR = 64'h1 << 5, B_DR = 64'h1 << 4, B_RI = 64'h1 << 1, B_LE = 64'h1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sc_valid = 0, ret_valid = 0, ext_valid = 0, ext_hv = 0, msr_wr_en = 0, fscr_wr_en = 0;
    logic [31:0] insn = '0;
    logic [11:0] ext_vec = '0;
    logic [63:0] cur_pc = '0, msr_wr_data = '0, fscr_wr_data = '0;
    logic redir_valid, redir_trap, mode_xlate, mode_priv, mode_le, mode_64, save_en;
    logic [63:0] redir_addr, msr_out, fscr_out;
    logic [1:0] save_idx;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    syscall_dispatch #(.XLEN(XLEN)) uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_entry(input logic [63:0] m, input logic vc);
        logic [63:0] r;
        r = (m | B_SF | B_LE) & ~(B_PR | B_SE | B_BE | B_FE0 | B_FE1 | B_IR | B_DR);
        if (!vc) r = r & ~(B_EE | B_RI);
        return r;
    endfunction

    task automatic wr_msr(input logic [63:0] v);
        msr_wr_en = 1; msr_wr_data = v; @(negedge clk); msr_wr_en = 0;
    endtask
    task automatic wr_fscr(input logic en, input logic [3:0] cause);
        fscr_wr_en = 1; fscr_wr_data = (64'(en) << 12) | (64'(cause) << 56);
        @(negedge clk); fscr_wr_en = 0;
    endtask
    task automatic do_sc(input logic [31:0] w, input logic [63:0] pc);
        sc_valid = 1; insn = w; cur_pc = pc; @(negedge clk); sc_valid = 0;
    endtask
    task automatic do_ret(input logic [31:0] w);
        ret_valid = 1; insn = w; @(negedge clk); ret_valid = 0;
    endtask
    task automatic do_ext(input logic hv, input logic [11:0] v, input logic [63:0] pc);
        ext_valid = 1; ext_hv = hv; ext_vec = v; cur_pc = pc; @(negedge clk); ext_valid = 0;
    endtask

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 msr", msr_out, B_SF | B_LE);
        chk("R1 fscr", fscr_out, 64'h1 << 12);
        chk("R1 redir", {redir_valid, redir_trap, save_en}, 0);

        // R3/R6/R8/R9/R11 all 128 levels, supervisor, enable set
        for (int lvl = 0; lvl < 128; lvl++) begin
            logic [63:0] pc;
            pat = B_EE | B_RI | B_IR | B_DR | B_SE | B_FE0 | (64'(lvl) << 32);
            pc = 64'h1000 + 64'(lvl) * 16;
            wr_msr(pat);
            chk("R11 msr write", msr_out, pat);
            do_sc(32'(lvl) << 5, pc);
            chk("R10 valid", {redir_valid, redir_trap}, 2'b11);
            chk("R3 vector", redir_addr, 64'h17000 + 64'(lvl) * 32);
            chk("R3 pair", save_idx, 2);
            chk("R6 vcall msr", msr_out, exp_entry(pat, 1));
            do_ret(32'h80);
            chk("R8 link return addr", redir_addr, pc + 4);
            chk("R8 msr restore", msr_out, pat);
            chk("R9 modes", {mode_xlate, mode_priv, mode_le, mode_64}, 4'b1100);
        end

        // R4/R5 facility check across privilege and enable
        for (int c = 0; c < 4; c++) begin
            logic pr, en;
            pr = c[1]; en = c[0];
            pat = B_EE | B_RI | (pr ? B_PR : 64'h0);
            wr_fscr(en, 4'h0);
            chk("R5 fscr write", fscr_out, 64'(en) << 12);
            wr_msr(pat);
            do_sc(32'd5 << 5, 64'h2000);
            if (pr && !en) begin
                chk("R4 facility vector", redir_addr, 64'hF60);
                chk("R4 facility pair", save_idx, 0);
                chk("R4 cause", fscr_out, 64'hC << 56);
                chk("R6 non-vcall msr", msr_out, exp_entry(pat, 0));
            end else begin
                chk("R4 normal vector", redir_addr, 64'h170A0);
                chk("R4 normal pair", save_idx, 2);
                chk("R4 cause kept", fscr_out, 64'(en) << 12);
                chk("R6 vcall msr", msr_out, exp_entry(pat, 1));
            end
        end
        wr_fscr(1, 4'h5);
        chk("R5 cause write", fscr_out, (64'h5 << 56) | (64'h1 << 12));

        // R2 legacy call and ordinary return
        pat = B_EE | B_PR | B_IR;
        wr_msr(pat);
        do_sc(32'h2 | (32'd9 << 5), 64'h3000);
        chk("R2 vector", redir_addr, 64'hC00);
        chk("R2 pair", save_idx, 0);
        chk("R6 legacy msr", msr_out, exp_entry(pat, 0));
        do_ret(32'h0);
        chk("R8 save return addr", redir_addr, 64'h3004);
        chk("R8 save msr", msr_out, pat);
        chk("R9 problem modes", {mode_xlate, mode_priv, mode_le, mode_64}, 4'b1000);

        // R7 hypervisor external trap, then hypervisor return
        pat = B_EE | B_DR | B_SF;
        wr_msr(pat);
        do_ext(1, 12'h503, 64'hABC0);
        chk("R7 ext vector", redir_addr, 64'h500);
        chk("R7 hv pair", save_idx, 1);
        chk("R6 ext msr", msr_out, exp_entry(pat, 0));
        do_ret(32'h200);
        chk("R8 hv return addr", redir_addr, 64'hABC0);
        chk("R8 hv msr", msr_out, pat);

        // R7 priority over a simultaneous call, ordinary pair
        wr_msr(B_RI);
        ext_valid = 1; ext_hv = 0; ext_vec = 12'h900; sc_valid = 1; insn = 32'd3 << 5;
        cur_pc = 64'h4444;
        @(negedge clk); ext_valid = 0; sc_valid = 0;
        chk("R7 priority vector", redir_addr, 64'h900);
        chk("R7 plain pair", save_idx, 0);
        do_ret(32'h0);
        chk("R7 saved pc", redir_addr, 64'h4444);
        chk("R7 saved msr", msr_out, B_RI);

        // R8 bit 7 wins over bit 9
        wr_msr(B_LE);
        do_sc(32'd127 << 5, 64'h5000);
        do_ret(32'h280);
        chk("R8 bit7 priority", redir_addr, 64'h5004);
        chk("R8 bit7 msr", msr_out, B_LE);

        // R9 mode sweep over PR, IR, LE, SF
        for (int k = 0; k < 16; k++) begin
            pat = (k[0] ? B_PR : 0) | (k[1] ? B_IR : 0) | (k[2] ? B_LE : 0) | (k[3] ? B_SF : 0);
            wr_msr(pat);
            do_sc(32'h2, 64'h6000);
            do_ret(32'h0);
            chk("R9 mode sweep", {mode_xlate, mode_priv, mode_le, mode_64},
                {k[0] | k[1], ~k[0], k[2], k[3]});
        end

        // R10 idle cycle
        @(negedge clk);
        chk("R10 idle", {redir_valid, redir_trap, save_en}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule